// File: doc/BRIEF.md
# Multi-Queue Prioritized Transmit Scheduler

This block chooses which transmit queue sends its next descriptor and which fixed-priority DMA channel that descriptor goes to. It holds the state of sixteen circular descriptor rings. Each ring has a read index, a write index, an active flag, an enable, a channel number and a service mode. A host loads this state through a small write-only configuration port. Descriptor storage, the DMA engines and air timing are outside the block. Pointers are plain 8-bit ring indices.

Each cycle the block offers at most one grant on a valid/ready stream: a queue index and a channel. The offer sits in an output register. Once it is raised it keeps its value until the consumer takes it with `gnt_ready`, so back-pressure only delays the offer and never changes it. Any number of queues may map to the same channel. Channel 7 (commands) ranks highest, then 3, 2, 1 and 0. Channels 4 to 6 are never served. Queues that share a channel take turns in round-robin order.

A queue in window mode streams its descriptors: each grant moves its read index on, and completions do not affect it. A queue in in-order mode has one frame in flight at a time. An acknowledgement retires that frame. A failed attempt offers the same descriptor again. When the retry budget runs out, the block raises a one-cycle drop report and moves past the frame. The command queue must be set to in-order mode.

Top module: `txs_sched`

## Requirements
- R1: After reset there is no grant offer and no drop report, and every queue is inactive with both indices at 0.
- R2: A queue can be granted only when it is active, enabled and has a valid channel, when it has no in-order frame in flight, and when its 8-bit write index differs from its read index. The indices wrap modulo 256, so read 255 and write 1 hold two descriptors.
- R3: Among eligible queues the grant goes to the highest ranked channel, in the order 7 > 3 > 2 > 1 > 0. A queue mapped to channel 4, 5 or 6 is never granted.
- R4: Eligible queues on the winning channel are served round-robin. The search starts at the queue after the one last granted on that channel, and each channel keeps its own pointer, which is 0 after reset.
- R5: While `gnt_valid` is high and `gnt_ready` is low, the offer stays up and `gnt_queue`/`gnt_chan` do not change. A new offer can be raised in the same cycle that the previous one is accepted.
- R6: A window-mode queue moves its read index on by one each time a grant from it is loaded, and it ignores completions.
- R7: An in-order queue holds at most one frame in flight. It is not granted again until a completion for it arrives.
- R8: For an in-order frame in flight, `cpl_ack`=1 moves the read index on. `cpl_ack`=0 leaves the read index alone, so the same descriptor is offered again.
- R9: On the RETRY_LIMIT-th failed attempt at one frame, `drop_valid` pulses for one cycle, the cycle after that completion, with `drop_queue` set to that queue. The read index then moves on and the retry count goes back to zero.
- R10: A completion for a queue that has no in-order frame in flight has no effect.
- R11: The status word (`cfg_field`=0) uses these bits: channel in bits 2:0, active in bit 3, window mode in bit 8 (1 = window, 0 = in-order), enable in bit 19.
- R12: `cfg_field`=1 writes the write index and `cfg_field`=2 writes the read index, each from `cfg_wdata[7:0]`. A host write to the read index takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_queue | input | 4 | Queue addressed by the write |
| cfg_field | input | 2 | 0 status word, 1 write index, 2 read index |
| cfg_wdata | input | 32 | Write data |
| cpl_valid | input | 1 | Completion report for a frame |
| cpl_queue | input | 4 | Queue the completion refers to |
| cpl_ack | input | 1 | 1 acknowledged, 0 failed attempt |
| gnt_valid | output | 1 | Grant offer present |
| gnt_ready | input | 1 | Consumer takes the offer |
| gnt_queue | output | 4 | Granted queue |
| gnt_chan | output | 3 | Channel for the granted descriptor |
| drop_valid | output | 1 | One-cycle frame-abandoned report |
| drop_queue | output | 4 | Queue whose frame was abandoned |

## Verification
The assertions assume that the host rewrites a queue's read index only while that queue is inactive and has nothing in flight. They also assume that completions refer to the queue index of a frame that was actually handed out. Stray completions are allowed because the block must ignore them. The stimulus keeps to this by loading read indices only just after reset, before any queue is activated. Later random host traffic only moves write indices, and the bench sends completions mostly to queues that its own model knows to be in flight. Ready, completion outcome and channel mapping are otherwise left free, and in random setups the command channel is kept in in-order mode.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int CH_W   = 3;
  localparam int N_CH   = 1 << CH_W;
  localparam int F_ACT  = 3;
  localparam int F_MODE = 8;
  localparam int F_EN   = 19;

  typedef enum logic [1:0] {
    FLD_STATUS = 2'd0,
    FLD_WPTR   = 2'd1,
    FLD_RPTR   = 2'd2
  } cfg_fld_e;

  // rank 0 marks a channel that is never served
  function automatic logic [2:0] chan_rank(input logic [CH_W-1:0] ch);
    case (ch)
      3'd7:    chan_rank = 3'd5;
      3'd3:    chan_rank = 3'd4;
      3'd2:    chan_rank = 3'd3;
      3'd1:    chan_rank = 3'd2;
      3'd0:    chan_rank = 3'd1;
      default: chan_rank = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/txs_queue_file.sv
module txs_queue_file
  import txs_pkg::*;
#(
  parameter int NQ          = 16,
  parameter int PW          = 8,
  parameter int RETRY_LIMIT = 3,
  localparam int QW = $clog2(NQ),
  localparam int RW = $clog2(RETRY_LIMIT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [QW-1:0]            cfg_queue,
  input  logic [1:0]               cfg_field,
  input  logic [31:0]              cfg_wdata,
  input  logic                     take,
  input  logic [QW-1:0]            take_queue,
  input  logic                     cpl_valid,
  input  logic [QW-1:0]            cpl_queue,
  input  logic                     cpl_ack,
  output logic [NQ-1:0]            elig,
  output logic [NQ-1:0][CH_W-1:0]  chan,
  output logic                     drop_valid,
  output logic [QW-1:0]            drop_queue
);
  logic [NQ-1:0] inflight;
  logic [NQ-1:0] last_try;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic [PW-1:0]   rd_r, wr_r;
    logic [CH_W-1:0] ch_r;
    logic            act_r, en_r, win_r, fly_r;
    logic [RW-1:0]   try_r;
    logic            hit, took, done, give_up;

    assign hit     = cfg_we && (cfg_queue == QW'(i));
    assign took    = take && (take_queue == QW'(i));
    assign done    = cpl_valid && (cpl_queue == QW'(i)) && fly_r;
    assign give_up = done && !cpl_ack && (try_r == RW'(RETRY_LIMIT - 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_r <= '0; wr_r <= '0; ch_r <= '0;
        act_r <= 1'b0; en_r <= 1'b0; win_r <= 1'b0; fly_r <= 1'b0;
        try_r <= '0;
      end else begin
        if (hit && cfg_field == FLD_STATUS) begin
          ch_r  <= cfg_wdata[CH_W-1:0];
          act_r <= cfg_wdata[F_ACT];
          win_r <= cfg_wdata[F_MODE];
          en_r  <= cfg_wdata[F_EN];
        end
        if (hit && cfg_field == FLD_WPTR) wr_r <= cfg_wdata[PW-1:0];
        if (hit && cfg_field == FLD_RPTR)
          rd_r <= cfg_wdata[PW-1:0];
        else if ((took && win_r) || (done && (cpl_ack || give_up)))
          rd_r <= rd_r + 1'b1;
        if (took && !win_r) fly_r <= 1'b1;
        else if (done)      fly_r <= 1'b0;
        if (done) try_r <= (cpl_ack || give_up) ? '0 : try_r + 1'b1;
      end
    end

    assign elig[i] = act_r && en_r && (chan_rank(ch_r) != 3'd0) &&
                     (wr_r != rd_r) && !fly_r;
    assign chan[i]     = ch_r;
    assign inflight[i] = fly_r;
    assign last_try[i] = (try_r == RW'(RETRY_LIMIT - 1));

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      took |-> !fly_r); // R7
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_valid <= 1'b0;
      drop_queue <= '0;
    end else begin
      drop_valid <= cpl_valid && !cpl_ack && inflight[cpl_queue] && last_try[cpl_queue];
      drop_queue <= cpl_queue;
    end
  end
endmodule

// File: rtl/txs_pick.sv
module txs_pick
  import txs_pkg::*;
#(
  parameter int NQ = 16,
  localparam int QW = $clog2(NQ)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NQ-1:0]            elig,
  input  logic [NQ-1:0][CH_W-1:0]  chan,
  input  logic                     adv,
  output logic                     pick_valid,
  output logic [QW-1:0]            pick_queue,
  output logic [CH_W-1:0]          pick_chan
);
  logic [N_CH-1:0][QW-1:0] last;
  logic [2:0]              best_rank;
  logic                    found;
  int                      idx;

  always_comb begin
    best_rank  = 3'd0;
    pick_chan  = '0;
    pick_queue = '0;
    found      = 1'b0;
    idx        = 0;
    for (int q = 0; q < NQ; q++) begin
      if (elig[q] && chan_rank(chan[q]) > best_rank) begin
        best_rank = chan_rank(chan[q]);
        pick_chan = chan[q];
      end
    end
    for (int k = 1; k <= NQ; k++) begin
      idx = int'(last[pick_chan]) + k;
      if (idx >= NQ) idx = idx - NQ;
      if (!found && elig[idx] && chan[idx] == pick_chan) begin
        found      = 1'b1;
        pick_queue = QW'(idx);
      end
    end
  end

  assign pick_valid = found;

  always_ff @(posedge clk) begin
    if (!rst_n)   last <= '0;
    else if (adv) last[pick_chan] <= pick_queue;
  end

  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> elig[pick_queue]); // R2
endmodule

// File: rtl/txs_sched.sv
module txs_sched
  import txs_pkg::*;
#(
  parameter int NQ          = 16,
  parameter int PW          = 8,
  parameter int RETRY_LIMIT = 3,
  localparam int QW = $clog2(NQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [QW-1:0]   cfg_queue,
  input  logic [1:0]      cfg_field,
  input  logic [31:0]     cfg_wdata,
  input  logic            cpl_valid,
  input  logic [QW-1:0]   cpl_queue,
  input  logic            cpl_ack,
  output logic            gnt_valid,
  input  logic            gnt_ready,
  output logic [QW-1:0]   gnt_queue,
  output logic [CH_W-1:0] gnt_chan,
  output logic            drop_valid,
  output logic [QW-1:0]   drop_queue
);
  logic [NQ-1:0]           elig;
  logic [NQ-1:0][CH_W-1:0] chan;
  logic                    pick_valid, load;
  logic [QW-1:0]           pick_queue;
  logic [CH_W-1:0]         pick_chan;

  assign load = pick_valid && (!gnt_valid || gnt_ready);

  txs_queue_file #(.NQ(NQ), .PW(PW), .RETRY_LIMIT(RETRY_LIMIT)) u_qf (
    .clk, .rst_n, .cfg_we, .cfg_queue, .cfg_field, .cfg_wdata,
    .take(load), .take_queue(pick_queue),
    .cpl_valid, .cpl_queue, .cpl_ack,
    .elig, .chan, .drop_valid, .drop_queue
  );

  txs_pick #(.NQ(NQ)) u_pick (
    .clk, .rst_n, .elig, .chan, .adv(load),
    .pick_valid, .pick_queue, .pick_chan
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_queue <= '0;
      gnt_chan  <= '0;
    end else if (load) begin
      gnt_valid <= 1'b1;
      gnt_queue <= pick_queue;
      gnt_chan  <= pick_chan;
    end else if (gnt_ready) begin
      gnt_valid <= 1'b0;
    end
  end

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_queue) && $stable(gnt_chan)); // R5
  AST_NO_IDLE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_chan <= 3'd3 || gnt_chan == 3'd7)); // R3
  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid |-> $past(cpl_valid && !cpl_ack) && drop_queue == $past(cpl_queue)); // R9
endmodule

// File: tb/tb_txs_sched.sv
module tb_txs_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NQ  = 16;
  localparam int LIM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_queue = '0;
  logic [1:0] cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic cpl_valid = 1'b0;
  logic [3:0] cpl_queue = '0;
  logic cpl_ack = 1'b0;
  logic gnt_ready = 1'b0;
  logic gnt_valid, drop_valid;
  logic [3:0] gnt_queue, drop_queue;
  logic [2:0] gnt_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  txs_sched #(.NQ(NQ), .PW(8), .RETRY_LIMIT(LIM)) dut (
    .clk, .rst_n, .cfg_we, .cfg_queue, .cfg_field, .cfg_wdata,
    .cpl_valid, .cpl_queue, .cpl_ack,
    .gnt_valid, .gnt_ready, .gnt_queue, .gnt_chan, .drop_valid, .drop_queue
  );

  int total = 0, bad = 0, cycles = 0;
  bit cur_rdy = 1'b1;
  string tag = "R1";
  int seen[$];
  int drops = 0, last_drop = -1;

  // reference model
  int m_rd[NQ], m_wr[NQ], m_ch[NQ], m_try[NQ];
  bit m_act[NQ], m_en[NQ], m_win[NQ], m_fly[NQ];
  int m_last[8];
  bit e_gv, e_dv;
  int e_gq, e_gc, e_dq;

  function automatic int rank(int c);
    case (c) 7: return 5; 3: return 4; 2: return 3; 1: return 2; 0: return 1; default: return 0; endcase
  endfunction

  function automatic bit m_elig(int q);
    return m_act[q] && m_en[q] && rank(m_ch[q]) != 0 && m_wr[q] != m_rd[q] && !m_fly[q];
  endfunction

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) begin
      m_rd[q] = 0; m_wr[q] = 0; m_ch[q] = 0; m_try[q] = 0;
      m_act[q] = 0; m_en[q] = 0; m_win[q] = 0; m_fly[q] = 0;
    end
    for (int c = 0; c < 8; c++) m_last[c] = 0;
    e_gv = 0; e_gq = 0; e_gc = 0; e_dv = 0; e_dq = 0;
  endtask

  task automatic model_step(bit we, int q, int f, int d, bit cv, int cq, bit ack, bit rdy);
    int best, bch, pq, take_q;
    bit pv, load, done, give;
    best = 0; bch = 0; pv = 0; pq = 0;
    for (int i = 0; i < NQ; i++)
      if (m_elig(i) && rank(m_ch[i]) > best) begin best = rank(m_ch[i]); bch = m_ch[i]; end
    for (int k = 1; k <= NQ; k++) begin
      int i = (m_last[bch] + k) % NQ;
      if (!pv && m_elig(i) && m_ch[i] == bch) begin pv = 1; pq = i; end
    end
    load = pv && (!e_gv || rdy);
    take_q = load ? pq : -1;
    done = cv && m_fly[cq];
    give = done && !ack && m_try[cq] == LIM - 1;
    e_dv = give; e_dq = cq;
    if (load) begin
      if (m_win[pq]) m_rd[pq] = (m_rd[pq] + 1) % 256; else m_fly[pq] = 1;
      m_last[bch] = pq; e_gv = 1; e_gq = pq; e_gc = bch;
    end else if (rdy) e_gv = 0;
    if (done) begin
      m_fly[cq] = 0;
      if (ack || give) begin m_rd[cq] = (m_rd[cq] + 1) % 256; m_try[cq] = 0; end
      else m_try[cq]++;
    end
    if (we) begin
      if (f == 0) begin
        m_ch[q] = d & 7; m_act[q] = d[3]; m_win[q] = d[8]; m_en[q] = d[19];
      end else if (f == 1) m_wr[q] = d & 255;
      else if (f == 2) m_rd[q] = d & 255;
    end
  endtask

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // called at a negedge; compares, drives, steps the model, waits one cycle
  task automatic cyc(bit we, int q, int f, int d, bit cv, int cq, bit ack);
    check("gnt_valid", gnt_valid, e_gv);
    if (e_gv) begin
      check("gnt_queue", gnt_queue, e_gq);
      check("gnt_chan", gnt_chan, e_gc);
    end
    check("drop_valid", drop_valid, e_dv);
    if (e_dv) check("drop_queue", drop_queue, e_dq);
    if (drop_valid) begin drops++; last_drop = drop_queue; end
    if (gnt_valid && cur_rdy) seen.push_back(int'(gnt_queue));
    cfg_we = we; cfg_queue = 4'(q); cfg_field = 2'(f); cfg_wdata = 32'(d);
    cpl_valid = cv; cpl_queue = 4'(cq); cpl_ack = ack; gnt_ready = cur_rdy;
    model_step(we, q, f, d, cv, cq, ack, cur_rdy);
    @(negedge clk);
  endtask

  task automatic wcfg(int q, int f, int d); cyc(1, q, f, d, 0, 0, 0); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic cpl(int q, bit ack); cyc(0, 0, 0, 0, 1, q, ack); endtask

  function automatic int sw(int ch, bit act, bit en, bit win);
    return ch | (int'(act) << 3) | (int'(win) << 8) | (int'(en) << 19);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cfg_we = 0; cpl_valid = 0; gnt_ready = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    seen.delete(); drops = 0; last_drop = -1;
  endtask

  task automatic check_seen(int exp[$]);
    check("grant count", seen.size(), exp.size());
    foreach (exp[i]) if (i < seen.size()) check("grant order", seen[i], exp[i]);
  endtask

  initial begin
    int waits = 0;
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    tag = "R1";
    check("reset gnt_valid", gnt_valid, 0);
    check("reset drop_valid", drop_valid, 0);
    idle(3);

    // R3 R11 R6: priority across channels, status word fields
    do_reset(); tag = "R3 R11 R6"; cur_rdy = 0;
    for (int q = 0; q < 6; q++) wcfg(q, 1, 1);
    wcfg(4, 0, sw(7, 1, 1, 1)); wcfg(3, 0, sw(3, 1, 1, 1)); wcfg(2, 0, sw(2, 1, 1, 1));
    wcfg(1, 0, sw(1, 1, 1, 1)); wcfg(0, 0, sw(0, 1, 1, 1)); wcfg(5, 0, sw(5, 1, 1, 1));
    cur_rdy = 1; idle(10);
    check_seen('{4, 3, 2, 1, 0});

    // R2 R12: wrap and enable gating
    do_reset(); tag = "R2 R12";
    wcfg(0, 2, 255); wcfg(0, 1, 1); wcfg(1, 1, 5);
    wcfg(1, 0, sw(3, 1, 0, 1));
    wcfg(0, 0, sw(2, 1, 1, 1));
    idle(8);
    check_seen('{0, 0});

    // R4 R5: round robin and held offer under back-pressure
    do_reset(); tag = "R4 R5"; cur_rdy = 0;
    foreach (seen[i]) ;
    wcfg(1, 1, 2); wcfg(5, 1, 2); wcfg(9, 1, 2);
    wcfg(1, 0, sw(1, 1, 1, 1)); wcfg(5, 0, sw(1, 1, 1, 1)); wcfg(9, 0, sw(1, 1, 1, 1));
    idle(5);
    check("held valid", gnt_valid, 1);
    check("held queue", gnt_queue, 1);
    cur_rdy = 1; idle(10);
    check_seen('{1, 5, 9, 1, 5, 9});

    // R7 R8 R9 R10: in-order queue, retries, drop, stray completion
    do_reset(); tag = "R7 R8 R9 R10";
    wcfg(2, 1, 1); wcfg(2, 0, sw(7, 1, 1, 0));
    idle(5);
    check("one frame in flight", seen.size(), 1);
    cpl(3, 0); idle(3);
    check("stray completion ignored", seen.size(), 1);
    cpl(2, 0); idle(4); cpl(2, 0); idle(4);
    check("retries re-offered", seen.size(), 3);
    cpl(2, 0); idle(4);
    check("drop count", drops, 1);
    check("drop queue", last_drop, 2);
    check("no grant after drop", seen.size(), 3);
    wcfg(3, 1, 2); wcfg(3, 0, sw(0, 1, 1, 0));
    idle(3); cpl(3, 1); idle(3); cpl(3, 1); idle(4);
    check("acks advance", seen.size(), 5);
    cpl(3, 1); idle(2);
    check("ack on idle queue ignored", seen.size(), 5);

    // random setups compared on every cycle
    for (int r = 0; r < 6; r++) begin
      int chs[6] = '{0, 1, 2, 3, 7, 5};
      do_reset(); tag = "R3 R4 R6 R7 R8 R9 R10"; cur_rdy = 1;
      for (int q = 0; q < NQ; q++) begin
        int w = $urandom % 256;
        wcfg(q, 2, (w - ($urandom % 6) + 256) % 256);
        wcfg(q, 1, w);
      end
      for (int q = 0; q < NQ; q++) begin
        int c = chs[$urandom % 6];
        bit win = (c == 7) ? 1'b0 : 1'($urandom % 2);
        wcfg(q, 0, sw(c, ($urandom % 10) < 8, ($urandom % 10) < 9, win));
      end
      for (int i = 0; i < 400; i++) begin
        int cq = $urandom % NQ;
        bit cv = 0;
        cur_rdy = ($urandom % 10) < 7;
        if (($urandom % 10) < 4) begin
          cv = 1;
          for (int k = 0; k < NQ; k++) if (m_fly[(cq + k) % NQ]) begin cq = (cq + k) % NQ; break; end
        end
        if (($urandom % 10) == 0) begin
          int q = $urandom % NQ;
          cyc(1, q, 1, (m_wr[q] + 1 + $urandom % 3) % 256, cv, cq, 1'($urandom % 3 != 0));
        end else
          cyc(0, 0, 0, 0, cv, cq, 1'($urandom % 3 != 0));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule